// File: doc/BRIEF.md
# Multiplexed Register Bus Slave

This block is the register-access front end of a larger device. A host reaches a small internal register file over an 8-bit shared bus that carries the address and the data on the same wires. The host first puts a register address on the bus and pulses an address-latch strobe. It then reads with an active-low read strobe or writes with an active-low write strobe, each qualified by an active-low chip select. All four strobes are asynchronous to the core clock. The block passes each of them through a two-flop synchronizer and finds their edges in the core clock domain. The bus value is delayed through a matching pipeline, so that the captured address and data line up with the strobe edges.

The register file holds interrupt status groups, interrupt mask groups and general scratch registers. Each status group collects eight interrupt source pulses into sticky bits. A status bit is cleared only when the host reads that status register. The block pulls the interrupt line low whenever a status bit is set and its mask bit is set. The line is modelled as an open-drain drive enable. The bus is modelled as a separate input, an output and an output enable.

Address map (byte addresses): status group g at 0x00+g, mask group g at 0x08+g, scratch register s at 0x10+s. Any other address reads 0x00 and ignores writes.

Top module: `muxRegBusSlave`

## Requirements
- R1: After the asynchronous active-low reset, `busOe` and `irqDriveLow` are 0, and every status, mask and scratch register reads 0x00.
- R2: The register address is the bus value present while `aleIn` is high, taken when `aleIn` falls. Bus values driven while `aleIn` is low never change the latched address.
- R3: `busOe` is 1 only while chip select and the read strobe are asserted (low), the write strobe is deasserted (high) and `aleIn` is low, all as seen through the synchronizers. While `busOe` is 1, `busOut` carries the addressed register. Unmapped addresses read 0x00.
- R4: A write stores the bus value present while both the write strobe and chip select are low. The store happens when either of them deasserts. Writes to status registers and to unmapped addresses change nothing.
- R5: With chip select held low permanently, reads and writes framed by the read and write strobes alone behave exactly as in R3 and R4.
- R6: A 1 on `irqSrc[8*g+i]` in any clock cycle sets bit i of status group g. The bit stays set until it is cleared by a read (R8).
- R7: `irqDriveLow` is 1 exactly when some status bit is 1 and the mask bit at the same position is 1. A mask value of 0x00 blocks the whole group.
- R8: When a read of a status register ends, the bits that were presented on the bus are cleared. A source pulse that arrives in the same clock cycle as the clear leaves its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aleIn | input | 1 | Address-latch strobe, active high, address taken on its falling edge |
| csN | input | 1 | Chip select, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| busIn | input | 8 | Shared bus as seen by the block (address, then write data) |
| busOut | output | 8 | Read data driven towards the shared bus |
| busOe | output | 1 | Output enable for `busOut` onto the shared bus |
| irqSrc | input | 16 | Interrupt source pulses, eight per status group |
| irqDriveLow | output | 1 | Open-drain interrupt drive enable (1 pulls the line low) |

## Verification
A strobe change made between clock edges is seen by the first synchronizer flop at the next edge and by the second flop one edge later. The resulting address latch, write store, output enable or clear then registers at the third edge. Every strobe step in the bench is therefore held for four clock cycles before the outputs are sampled or the next step is made. A source pulse sets its status bit at the edge that samples it, and `irqDriveLow` follows at once. Source checks are sampled two cycles after the pulse. The same-cycle clear-and-set case is timed so that the pulse is presented exactly two cycles after the read strobe rises, which is the edge at which the clear registers.

// File: rtl/regBusPkg.sv
package regBusPkg;

  // Strobes handed from the bus control to the register datapath.
  typedef struct packed {
    logic latchAddr;  // address phase finished, take address from delayed bus
    logic writeEn;    // write phase finished, store delayed bus data
    logic readOe;     // read phase active, drive addressed register
    logic readClr;    // read phase finished, clear presented status bits
  } busStrobes_t;

endpackage

// File: rtl/busCtrl.sv
module busCtrl
  import regBusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aleIn,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  output busStrobes_t strobes
);

  localparam int NUM_STB = 4;
  localparam int STAGES  = 3;  // two synchronizer flops plus one history flop
  // Bit order: 3 = ale, 2 = cs, 1 = rd, 0 = wr. Idle levels at reset.
  localparam logic [NUM_STB-1:0] IDLE_LVL = 4'b0111;

  logic [NUM_STB-1:0] rawStb;
  logic [NUM_STB-1:0] syncQ [STAGES];

  assign rawStb = {aleIn, csN, rdN, wrN};

  for (genvar b = 0; b < NUM_STB; b++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int s = 0; s < STAGES; s++) syncQ[s][b] <= IDLE_LVL[b];
      end else begin
        syncQ[0][b] <= rawStb[b];
        for (int s = 1; s < STAGES; s++) syncQ[s][b] <= syncQ[s-1][b];
      end
    end
  end

  logic aleNow, alePrev;
  logic readNow, readPrev, writeNow, writePrev;

  assign aleNow    = syncQ[1][3];
  assign alePrev   = syncQ[2][3];
  assign readNow   = !syncQ[1][2] && !syncQ[1][1] && syncQ[1][0] && !aleNow;
  assign readPrev  = !syncQ[2][2] && !syncQ[2][1] && syncQ[2][0] && !alePrev;
  assign writeNow  = !syncQ[1][2] && !syncQ[1][0] && syncQ[1][1];
  assign writePrev = !syncQ[2][2] && !syncQ[2][0] && syncQ[2][1];

  always_comb begin
    strobes.latchAddr = alePrev && !aleNow;
    strobes.writeEn   = writePrev && !writeNow;
    strobes.readOe    = readNow;
    strobes.readClr   = readPrev && !readNow;
  end

endmodule

// File: rtl/regFileDp.sv
module regFileDp
  import regBusPkg::*;
#(
  parameter int DW        = 8,
  parameter int NUM_GRP   = 2,
  parameter int NUM_SCR   = 4,
  parameter int STAT_BASE = 8'h00,
  parameter int MASK_BASE = 8'h08,
  parameter int SCR_BASE  = 8'h10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobes_t           strobes,
  input  logic [DW-1:0]         busIn,
  input  logic [NUM_GRP*DW-1:0] irqSrc,
  output logic [DW-1:0]         busOut,
  output logic                  busOe,
  output logic                  irqDriveLow,
  output logic [NUM_GRP*DW-1:0] statFlat,
  output logic [NUM_GRP*DW-1:0] maskFlat,
  output logic [DW-1:0]         addrQ
);

  localparam int PIPE = 3;  // matches synchronizer depth plus history

  logic [DW-1:0] busPipe [PIPE];
  logic [DW-1:0] statReg [NUM_GRP];
  logic [DW-1:0] maskReg [NUM_GRP];
  logic [DW-1:0] scrReg  [NUM_SCR];
  logic [DW-1:0] busLate;
  logic [DW-1:0] rdData;
  int addrInt, statIdx, maskIdx, scrIdx;
  logic statHit, maskHit, scrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < PIPE; s++) busPipe[s] <= '0;
    end else begin
      busPipe[0] <= busIn;
      for (int s = 1; s < PIPE; s++) busPipe[s] <= busPipe[s-1];
    end
  end
  assign busLate = busPipe[PIPE-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  addrQ <= '0;
    else if (strobes.latchAddr) addrQ <= busLate;
  end

  always_comb begin
    addrInt = int'(addrQ);
    statIdx = addrInt - STAT_BASE;
    maskIdx = addrInt - MASK_BASE;
    scrIdx  = addrInt - SCR_BASE;
    statHit = (statIdx >= 0) && (statIdx < NUM_GRP);
    maskHit = (maskIdx >= 0) && (maskIdx < NUM_GRP);
    scrHit  = (scrIdx >= 0) && (scrIdx < NUM_SCR);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    logic [DW-1:0] clrBits;
    assign clrBits = (strobes.readClr && statHit && statIdx == g) ? busOut : '0;

    // Set has priority over clear: a source pulse in the clear cycle survives.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statReg[g] <= '0;
      else       statReg[g] <= (statReg[g] & ~clrBits) | irqSrc[g*DW +: DW];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        maskReg[g] <= '0;
      else if (strobes.writeEn && maskHit && maskIdx == g) maskReg[g] <= busLate;
    end

    assign statFlat[g*DW +: DW] = statReg[g];
    assign maskFlat[g*DW +: DW] = maskReg[g];
  end

  for (genvar s = 0; s < NUM_SCR; s++) begin : gScr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       scrReg[s] <= '0;
      else if (strobes.writeEn && scrHit && scrIdx == s) scrReg[s] <= busLate;
    end
  end

  always_comb begin
    rdData = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (statHit && statIdx == g) rdData = statReg[g];
      if (maskHit && maskIdx == g) rdData = maskReg[g];
    end
    for (int s = 0; s < NUM_SCR; s++) begin
      if (scrHit && scrIdx == s) rdData = scrReg[s];
    end
  end

  // busOut holds the last presented value after the read so the clear uses it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOe  <= 1'b0;
      busOut <= '0;
    end else begin
      busOe <= strobes.readOe;
      if (strobes.readOe) busOut <= rdData;
    end
  end

  assign irqDriveLow = |(statFlat & maskFlat);

endmodule

// File: rtl/muxRegBusSlave.sv
module muxRegBusSlave
  import regBusPkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_GRP = 2,
  parameter int NUM_SCR = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  aleIn,
  input  logic                  csN,
  input  logic                  rdN,
  input  logic                  wrN,
  input  logic [DW-1:0]         busIn,
  output logic [DW-1:0]         busOut,
  output logic                  busOe,
  input  logic [NUM_GRP*DW-1:0] irqSrc,
  output logic                  irqDriveLow
);

  busStrobes_t           ctlStr;
  logic [NUM_GRP*DW-1:0] statFlat;
  logic [NUM_GRP*DW-1:0] maskFlat;
  logic [DW-1:0]         addrQ;

  busCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .aleIn   (aleIn),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .strobes (ctlStr)
  );

  regFileDp #(
    .DW      (DW),
    .NUM_GRP (NUM_GRP),
    .NUM_SCR (NUM_SCR)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (ctlStr),
    .busIn       (busIn),
    .irqSrc      (irqSrc),
    .busOut      (busOut),
    .busOe       (busOe),
    .irqDriveLow (irqDriveLow),
    .statFlat    (statFlat),
    .maskFlat    (maskFlat),
    .addrQ       (addrQ)
  );

endmodule

// File: rtl/regBusChk.sv
module regBusChk #(
  parameter int DW    = 8,
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             rdN,
  input logic             wrN,
  input logic             busOe,
  input logic             irqDriveLow,
  input logic [SRC_W-1:0] irqSrc,
  input logic [SRC_W-1:0] statFlat,
  input logic [SRC_W-1:0] maskFlat,
  input logic [DW-1:0]    addrQ,
  input logic             latchAddr,
  input logic             readClr
);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!busOe && !irqDriveLow && statFlat == '0) // R1
        else $error("reset state not quiet");
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(latchAddr) |-> $stable(addrQ)) // R2
    else $error("address changed without latch");

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> $past(!csN && !rdN && wrN, 3)) // R3
    else $error("output enable without read strobes");

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(readClr) |-> (($past(statFlat) & ~statFlat) == '0)) // R6
    else $error("status bit dropped without read");

  AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|irqSrc) |=> ((statFlat & $past(irqSrc)) == $past(irqSrc))) // R6
    else $error("source pulse not captured");

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskFlat == '0) |-> !irqDriveLow) // R7
    else $error("interrupt asserted with all masks clear");

endmodule

bind muxRegBusSlave regBusChk #(.DW(DW), .SRC_W(NUM_GRP*DW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .csN         (csN),
  .rdN         (rdN),
  .wrN         (wrN),
  .busOe       (busOe),
  .irqDriveLow (irqDriveLow),
  .irqSrc      (irqSrc),
  .statFlat    (statFlat),
  .maskFlat    (maskFlat),
  .addrQ       (addrQ),
  .latchAddr   (ctlStr.latchAddr),
  .readClr     (ctlStr.readClr)
);

// File: tb/sim_muxRegBusSlave.sv
module sim_muxRegBusSlave;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int NUM_GRP    = 2;
  localparam int NUM_SCR    = 4;
  localparam int SRC_W      = NUM_GRP * DW;
  localparam int STEP       = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             aleIn = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [DW-1:0]    busIn = '0;
  logic [DW-1:0]    busOut;
  logic             busOe;
  logic [SRC_W-1:0] irqSrc = '0;
  logic             irqDriveLow;

  logic [DW-1:0] mStat [NUM_GRP];
  logic [DW-1:0] mMask [NUM_GRP];
  logic [DW-1:0] mScr  [NUM_SCR];
  bit csPerm = 1'b0;
  bit done   = 1'b0;
  int checks = 0, fails = 0;

  muxRegBusSlave #(.DW(DW), .NUM_GRP(NUM_GRP), .NUM_SCR(NUM_SCR)) u0 (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .irqSrc(irqSrc),
    .irqDriveLow(irqDriveLow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] expRead(input logic [DW-1:0] a);
    int ai = int'(a);
    if (ai < NUM_GRP) return mStat[ai];
    if (ai >= 8 && ai < 8 + NUM_GRP) return mMask[ai-8];
    if (ai >= 16 && ai < 16 + NUM_SCR) return mScr[ai-16];
    return '0;
  endfunction

  function automatic logic expIrq();
    logic r = 1'b0;
    for (int g = 0; g < NUM_GRP; g++) r = r | (|(mStat[g] & mMask[g]));
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAddr(input logic [DW-1:0] a);
    busIn = a; aleIn = 1'b1; idle(STEP);
    aleIn = 1'b0; idle(STEP);
  endtask

  // endByCs: finish the write by raising chip select instead of the write strobe.
  task automatic doWrite(input logic [DW-1:0] a, input logic [DW-1:0] d, input bit endByCs);
    int ai = int'(a);
    setAddr(a);
    busIn = d; wrN = 1'b0;
    if (!csPerm) csN = 1'b0;
    idle(STEP);
    if (endByCs && !csPerm) begin
      csN = 1'b1; idle(STEP); wrN = 1'b1;
    end else begin
      wrN = 1'b1; idle(STEP);
      if (!csPerm) csN = 1'b1;
    end
    busIn = DW'($urandom);
    idle(STEP);
    if (ai >= 8 && ai < 8 + NUM_GRP) mMask[ai-8] = d;
    if (ai >= 16 && ai < 16 + NUM_SCR) mScr[ai-16] = d;
  endtask

  task automatic doRead(input logic [DW-1:0] a, input string req);
    logic [DW-1:0] exp;
    int ai = int'(a);
    setAddr(a);
    busIn = DW'($urandom);  // junk on the bus after the address phase (R2)
    exp = expRead(a);
    rdN = 1'b0;
    if (!csPerm) csN = 1'b0;
    idle(STEP);
    chk({req, " oe during read"}, {7'd0, busOe}, 8'd1);
    chk({req, " read data"}, busOut, exp);
    rdN = 1'b1;
    if (!csPerm) csN = 1'b1;
    idle(STEP);
    chk({req, " oe after read (R3)"}, {7'd0, busOe}, 8'd0);
    if (ai < NUM_GRP) mStat[ai] = mStat[ai] & ~exp;
  endtask

  task automatic pulseSrc(input logic [SRC_W-1:0] v);
    irqSrc = v; idle(1);
    irqSrc = '0; idle(2);
    for (int g = 0; g < NUM_GRP; g++) mStat[g] = mStat[g] | v[g*DW +: DW];
  endtask

  task automatic chkIrq(input string req);
    chk(req, {7'd0, irqDriveLow}, {7'd0, expIrq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] a;
    void'($urandom(32'd2024));
    for (int g = 0; g < NUM_GRP; g++) begin mStat[g] = '0; mMask[g] = '0; end
    for (int s = 0; s < NUM_SCR; s++) mScr[s] = '0;

    idle(3);
    chk("R1 oe in reset", {7'd0, busOe}, 8'd0);
    chk("R1 irq in reset", {7'd0, irqDriveLow}, 8'd0);
    rstN = 1'b1;
    idle(3);
    doRead(8'h00, "R1");
    doRead(8'h09, "R1");
    doRead(8'h13, "R1");

    // R4: write ended by the write strobe, then by chip select
    doWrite(8'h10, 8'hA5, 1'b0);
    doRead(8'h10, "R4");
    doWrite(8'h11, 8'h3C, 1'b1);
    doRead(8'h11, "R4");
    // R4: status and unmapped writes have no effect
    doWrite(8'h00, 8'hFF, 1'b0);
    doRead(8'h00, "R4");
    doWrite(8'h05, 8'h77, 1'b0);
    doRead(8'h05, "R3");

    // R2: address stays put although the bus carries other values
    setAddr(8'h11);
    busIn = 8'h10; idle(STEP);
    busIn = 8'h08; idle(STEP);
    rdN = 1'b0; csN = 1'b0; idle(STEP);
    chk("R2 held address", busOut, 8'h3C);
    rdN = 1'b1; csN = 1'b1; idle(STEP);

    // R6/R7: masked source does not interrupt, unmasked does
    pulseSrc(16'h0100);
    chkIrq("R7 masked group");
    doWrite(8'h09, 8'h01, 1'b0);
    chkIrq("R7 unmasked bit");
    doRead(8'h01, "R6");
    chkIrq("R8 clear releases irq");

    // R8: a source pulse in the clear cycle survives
    doWrite(8'h08, 8'hFF, 1'b0);
    pulseSrc(16'h000F);
    setAddr(8'h00);
    rdN = 1'b0; csN = 1'b0; idle(STEP);
    chk("R8 status before clear", busOut, 8'h0F);
    rdN = 1'b1; csN = 1'b1;
    idle(2);
    irqSrc = 16'h0001; idle(1); irqSrc = '0;
    idle(STEP);
    mStat[0] = 8'h01;
    chkIrq("R8 irq after same-cycle event");
    doRead(8'h00, "R8");

    // R5: chip select tied low
    csPerm = 1'b1; csN = 1'b0; idle(STEP);
    doWrite(8'h12, 8'h5A, 1'b0);
    doRead(8'h12, "R5");
    pulseSrc(16'h8000);
    doRead(8'h01, "R5");

    // random mix, chip-select mode switching every 20 operations
    for (int it = 0; it < 80; it++) begin
      if (it % 20 == 0) begin
        csPerm = ((it / 20) % 2) == 1;
        csN = csPerm ? 1'b0 : 1'b1;
        idle(STEP);
      end
      a = DW'($urandom % 24);
      case ($urandom % 3)
        0: doWrite(a, DW'($urandom), bit'($urandom % 2));
        1: doRead(a, csPerm ? "R5" : "R3");
        default: pulseSrc(SRC_W'($urandom));
      endcase
      chkIrq("R7 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule